// File: doc/BRIEF.md
# External Interrupt Request Prioritizer

This block takes a small set of external interrupt request pins, brings each one into the clock domain, and turns it into a pending request. Each pin is set up on its own to be level sensed or edge sensed. A level-sensed pin presents its synchronized state directly. An edge-sensed pin first passes through a pulse-width filter. When the filter accepts a pulse, the event is held in a request bit, and that bit stays set until software clears it with a read-then-write handshake.

Each source carries a programmable priority, and a priority of zero shuts the source off. The block picks the pending source with the highest priority, breaking ties toward the lowest index, and presents it as an index and a level. It asks the CPU for service only when that level is strictly above the CPU's current mask level. The mask is an input only, and the block never changes it.

Software reaches the configuration through a small register window with single-cycle write strobes and registered reads.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every sense-select bit, request bit and priority field is 0, `irq_valid_o`, `irq_id_o`, `irq_level_o` and `cpu_req_o` are 0, and `reg_rdata_o` is 0.
- R2: A pin in level mode (sense bit 0) shows its pin state, delayed by the two-flop synchronizer, both in the request register and at the arbiter. The pin is visible at the outputs two clock edges after it changes, and the request is not latched.
- R3: In edge mode (sense bit 1), a high pulse that lasts at least three consecutive clock cycles sets the source's request bit. A pulse that lasts only two cycles sets nothing.
- R4: A request bit set in edge mode stays set after its pin returns low.
- R5: Writing 0 to a set edge request bit clears it only if software has read that bit as 1 since it was last set. A write of 0 without such a read leaves the bit set. A write of 1 has no effect. This clear also removes a stale request that becomes visible when a pin is switched from level to edge mode.
- R6: If an edge is recognized in the same cycle as a clearing write, the bit stays set. A fresh read of 1 is then needed before a write of 0 can clear it.
- R7: Register map, with reads returned on `reg_rdata_o` in the cycle after `reg_rd_i`. Address 0 holds the sense selects, with bit i for source i. Address 1 holds the request bits, with bit i for source i. Priority registers start at address 2: source i sits in the register at address 2 + i/4, bits [4*(i%4)+3 : 4*(i%4)]. Field bits that belong to no source, and unmapped addresses, read as 0.
- R8: A source whose priority is 0 is never reported, whatever its request state.
- R9: `irq_id_o` and `irq_level_o` give the pending nonzero-priority source with the highest priority, with the lowest index winning a tie, and `irq_valid_o` is 1. When no such source exists, all three are 0.
- R10: `cpu_req_o` is 1 exactly when `irq_valid_o` is 1 and `irq_level_o` is strictly greater than `cpu_mask_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_i | input | NUM_SRC | Asynchronous request pins, active high |
| cpu_mask_i | input | PRIO_W | CPU's current interrupt mask level |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| irq_valid_o | output | 1 | A source with nonzero priority is pending |
| irq_id_o | output | ID_W | Index of the winning source |
| irq_level_o | output | PRIO_W | Priority of the winning source |
| cpu_req_o | output | 1 | Service request to the CPU |

## Verification
The bench builds the block with its defaults: six sources, 4-bit priorities, a 16-bit data path, a two-flop synchronizer and a three-cycle minimum pulse. With six sources there are only 64 level-mode pin patterns, so the bench drives every one of them against four priority sets: distinct values, zeros mixed with duplicates, all equal, and all zero. For each pattern it sets the mask from the pattern number, which covers the tie-break, masking by a zero priority, and the strict comparison with the mask, including equality. With the three-cycle minimum, pulses of two and three cycles sit exactly on the filter boundary. The same short latency lets a clearing write be placed on the very cycle an edge is accepted.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

   // Register window layout (behavioural: software decodes these addresses)
   localparam int unsigned REG_SENSE     = 0;
   localparam int unsigned REG_PENDING   = 1;
   localparam int unsigned REG_PRIO_BASE = 2;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/irq_pin_filter.sv
// Synchronizes one request pin and qualifies edges by pulse width.
module irq_pin_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_PULSE   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic edge_evt_o
);
   localparam int unsigned CNT_W = $clog2(MIN_PULSE + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CNT_W-1:0]       run_q;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_single
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= pin_i;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
         end
      end
   endgenerate

   assign level_o = sync_q[SYNC_STAGES-1];

   // Count consecutive high samples, saturating at MIN_PULSE.
   always_ff @(posedge clk) begin
      if (!rst_n)                          run_q <= '0;
      else if (!level_o)                   run_q <= '0;
      else if (run_q != CNT_W'(MIN_PULSE)) run_q <= run_q + 1'b1;
   end

   assign edge_evt_o = level_o && (run_q == CNT_W'(MIN_PULSE - 1));

   // R3: a single accepted pulse yields one event only
   a_r3_one_event_per_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt_o |=> !edge_evt_o);

   generate
      if (MIN_PULSE > 1) begin : g_width_chk
         // R3: an event is never produced on the first high sample
         a_r3_event_after_run: assert property (@(posedge clk) disable iff (!rst_n)
            edge_evt_o |-> $past(level_o));
      end
   endgenerate

endmodule

// File: rtl/irq_req_latch.sv
// Holds one edge request with a read-armed clear handshake.
module irq_req_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic arm_i,
   input  logic clr_i,
   output logic req_o
);
   logic req_q;
   logic armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         armed_q <= 1'b0;
      end else if (set_i) begin
         req_q   <= 1'b1;
         armed_q <= 1'b0;
      end else if (clr_i && armed_q) begin
         req_q   <= 1'b0;
         armed_q <= 1'b0;
      end else if (arm_i && req_q) begin
         armed_q <= 1'b1;
      end
   end

   assign req_o = req_q;

   // R5: a request drops only through an armed clearing write
   a_r5_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_q) |-> $past(armed_q && clr_i));

   // R6: a new edge wins over a simultaneous clear and disarms
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> (req_q && !armed_q));

endmodule

// File: rtl/irq_prio_arbiter.sv
// Picks the highest nonzero priority; lowest index wins on ties.
module irq_prio_arbiter #(
   parameter int unsigned NUM_SRC = 6,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned ID_W    = 3
) (
   input  logic [NUM_SRC-1:0]        req_i,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
   output logic                      valid_o,
   output logic [ID_W-1:0]           id_o,
   output logic [PRIO_W-1:0]         level_o
);
   logic [PRIO_W-1:0] best_lvl;
   logic [ID_W-1:0]   best_id;

   always_comb begin
      best_lvl = '0;
      best_id  = '0;
      // Scan downward so that on equal priority the lower index overwrites.
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] != '0) &&
             (prio_i[i*PRIO_W +: PRIO_W] >= best_lvl)) begin
            best_lvl = prio_i[i*PRIO_W +: PRIO_W];
            best_id  = ID_W'(i);
         end
      end
   end

   assign valid_o = (best_lvl != '0);
   assign id_o    = best_id;
   assign level_o = best_lvl;

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import ext_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 6,
   parameter int unsigned PRIO_W      = 4,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_PULSE   = 3,
   localparam int unsigned ID_W       = $clog2(NUM_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SRC-1:0] irq_pin_i,
   input  logic [PRIO_W-1:0]  cpu_mask_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic              reg_wr_i,
   input  logic              reg_rd_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic              irq_valid_o,
   output logic [ID_W-1:0]    irq_id_o,
   output logic [PRIO_W-1:0]  irq_level_o,
   output logic              cpu_req_o
);
   localparam int unsigned FIELDS_PER_REG = DATA_W / PRIO_W;
   localparam int unsigned PRIO_REGS      = ceil_div(NUM_SRC, FIELDS_PER_REG);

   // Elaboration-time parameter checks
   initial begin
      if (NUM_SRC < 2 || NUM_SRC > DATA_W)
         $fatal(1, "ext_irq_ctrl: NUM_SRC must be in 2..DATA_W");
      if (PRIO_W < 1 || PRIO_W > DATA_W)
         $fatal(1, "ext_irq_ctrl: PRIO_W must be in 1..DATA_W");
      if (SYNC_STAGES < 1 || MIN_PULSE < 1)
         $fatal(1, "ext_irq_ctrl: SYNC_STAGES and MIN_PULSE must be nonzero");
      if (REG_PRIO_BASE + PRIO_REGS > (1 << ADDR_W))
         $fatal(1, "ext_irq_ctrl: ADDR_W too small for the register window");
   end

   logic [NUM_SRC-1:0]        sense_q;
   logic [PRIO_W-1:0]         prio_q [NUM_SRC];
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic [DATA_W-1:0]         rdata_q;
   logic [DATA_W-1:0]         rd_mux;

   logic [NUM_SRC-1:0] pin_level;
   logic [NUM_SRC-1:0] pin_evt;
   logic [NUM_SRC-1:0] latch_req;
   logic [NUM_SRC-1:0] req_view;

   logic sel_sense, sel_pending;
   assign sel_sense   = (reg_addr_i == ADDR_W'(REG_SENSE));
   assign sel_pending = (reg_addr_i == ADDR_W'(REG_PENDING));

   // Per-source front end
   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
         irq_pin_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .MIN_PULSE   (MIN_PULSE)
         ) u_filter (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (irq_pin_i[g]),
            .level_o    (pin_level[g]),
            .edge_evt_o (pin_evt[g])
         );

         irq_req_latch u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (pin_evt[g] && sense_q[g]),
            .arm_i (reg_rd_i && sel_pending && sense_q[g]),
            .clr_i (reg_wr_i && sel_pending && !reg_wdata_i[g]),
            .req_o (latch_req[g])
         );

         assign req_view[g] = sense_q[g] ? latch_req[g] : pin_level[g];
         assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
      end
   endgenerate

   // Configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sense_q <= '0;
      end else if (reg_wr_i && sel_sense) begin
         sense_q <= reg_wdata_i[NUM_SRC-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SRC; s++) prio_q[s] <= '0;
      end else if (reg_wr_i) begin
         for (int s = 0; s < NUM_SRC; s++) begin
            if (reg_addr_i == ADDR_W'(REG_PRIO_BASE + s / FIELDS_PER_REG))
               prio_q[s] <= reg_wdata_i[(s % FIELDS_PER_REG)*PRIO_W +: PRIO_W];
         end
      end
   end

   // Read path
   always_comb begin
      rd_mux = '0;
      if (sel_sense)   rd_mux[NUM_SRC-1:0] = sense_q;
      if (sel_pending) rd_mux[NUM_SRC-1:0] = req_view;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (reg_addr_i == ADDR_W'(REG_PRIO_BASE + s / FIELDS_PER_REG))
            rd_mux[(s % FIELDS_PER_REG)*PRIO_W +: PRIO_W] = prio_q[s];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        rdata_q <= '0;
      else if (reg_rd_i) rdata_q <= rd_mux;
   end

   assign reg_rdata_o = rdata_q;

   // Priority selection
   irq_prio_arbiter #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .ID_W    (ID_W)
   ) u_arb (
      .req_i   (req_view),
      .prio_i  (prio_flat),
      .valid_o (irq_valid_o),
      .id_o    (irq_id_o),
      .level_o (irq_level_o)
   );

   assign cpu_req_o = irq_valid_o && (irq_level_o > cpu_mask_i);

   // R9: the reported source is actually requesting
   a_r9_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid_o |-> req_view[irq_id_o]);

   // R8: the reported level matches a nonzero programmed priority
   a_r8_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid_o |-> (prio_flat[irq_id_o*PRIO_W +: PRIO_W] == irq_level_o &&
                       irq_level_o != '0));

   // R9: with nothing enabled and pending, the outputs idle
   a_r9_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_view & ~sense_q & ~pin_level) == req_view && req_view == '0)
         |-> (!irq_valid_o && irq_level_o == '0));

   // R10: never a CPU request without a reported source
   a_r10_req_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req_o |-> irq_valid_o);

   // R7: read data holds between read strobes
   a_r7_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_i |=> $stable(reg_rdata_o));

endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
   localparam int NSRC = 6;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [5:0]  irq_pin_i;
   logic [3:0]  cpu_mask_i;
   logic [2:0]  reg_addr_i;
   logic        reg_wr_i;
   logic        reg_rd_i;
   logic [15:0] reg_wdata_i;
   logic [15:0] reg_rdata_o;
   logic        irq_valid_o;
   logic [2:0]  irq_id_o;
   logic [3:0]  irq_level_o;
   logic        cpu_req_o;

   int checks = 0;
   int errors = 0;
   int prio [NSRC];

   always #4 clk = ~clk;

   ext_irq_ctrl u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_pin_i   (irq_pin_i),
      .cpu_mask_i  (cpu_mask_i),
      .reg_addr_i  (reg_addr_i),
      .reg_wr_i    (reg_wr_i),
      .reg_rd_i    (reg_rd_i),
      .reg_wdata_i (reg_wdata_i),
      .reg_rdata_o (reg_rdata_o),
      .irq_valid_o (irq_valid_o),
      .irq_id_o    (irq_id_o),
      .irq_level_o (irq_level_o),
      .cpu_req_o   (cpu_req_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr_i = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr_i = a; reg_rd_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_rd_i = 1'b0;
      d = reg_rdata_o;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int prio_of(input int set, input int i);
      int a [NSRC] = '{3, 10, 1, 8, 15, 6};
      int b [NSRC] = '{0, 5, 5, 0, 12, 12};
      case (set)
         0: return a[i];
         1: return b[i];
         2: return 9;
         default: return 0;
      endcase
   endfunction

   task automatic load_prio(input int set);
      for (int i = 0; i < NSRC; i++) prio[i] = prio_of(set, i);
      reg_write(3'd2, 16'((prio[3] << 12) | (prio[2] << 8) | (prio[1] << 4) | prio[0]));
      reg_write(3'd3, 16'((prio[5] << 4) | prio[4]));
   endtask

   task automatic pulse(input int pin, input int len);
      @(negedge clk);
      irq_pin_i[pin] = 1'b1;
      repeat (len) @(negedge clk);
      irq_pin_i[pin] = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [15:0] rd;
      rst_n = 1'b0; irq_pin_i = '0; cpu_mask_i = '0;
      reg_addr_i = '0; reg_wr_i = 1'b0; reg_rd_i = 1'b0; reg_wdata_i = '0;
      wait_cyc(4);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 rdata",  reg_rdata_o, 0);
      chk("R1 valid",  irq_valid_o, 0);
      chk("R1 id",     irq_id_o, 0);
      chk("R1 level",  irq_level_o, 0);
      chk("R1 cpu_req", cpu_req_o, 0);
      reg_read(3'd0, rd); chk("R1 sense reg", rd, 0);
      reg_read(3'd1, rd); chk("R1 pending reg", rd, 0);
      reg_read(3'd2, rd); chk("R1 prio reg0", rd, 0);
      reg_read(3'd3, rd); chk("R1 prio reg1", rd, 0);

      // R7: priority layout and unused bits
      reg_write(3'd2, 16'h4321);
      reg_read(3'd2, rd); chk("R7 prio reg0 readback", rd, 16'h4321);
      reg_write(3'd3, 16'hFFA5);
      reg_read(3'd3, rd); chk("R7 prio reg1 unused bits zero", rd, 16'h00A5);
      reg_read(3'd6, rd); chk("R7 unmapped address", rd, 0);
      reg_write(3'd0, 16'hFF2A);
      reg_read(3'd0, rd); chk("R7 sense reg readback", rd, 16'h002A);
      reg_write(3'd0, 16'h0000);

      // R2: two-stage latency in level mode (source 0 priority 1)
      @(negedge clk);
      irq_pin_i[0] = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R2 one edge not yet visible", irq_valid_o, 0);
      @(posedge clk); @(negedge clk);
      chk("R2 visible after two edges", irq_valid_o, 1);
      irq_pin_i = 6'b101101;
      wait_cyc(3);
      reg_read(3'd1, rd); chk("R2 pending follows pins", rd, 16'h002D);
      irq_pin_i = '0;
      wait_cyc(3);
      reg_read(3'd1, rd); chk("R2 level not latched", rd, 0);

      // R8 R9 R10: sweep every pin pattern over four priority sets
      for (int set = 0; set < 4; set++) begin
         load_prio(set);
         for (int pat = 0; pat < 64; pat++) begin
            int bl, bi;
            logic ecpu;
            bl = 0; bi = 0;
            for (int i = NSRC - 1; i >= 0; i--)
               if (pat[i] && prio[i] != 0 && prio[i] >= bl) begin bl = prio[i]; bi = i; end
            ecpu = (bl != 0) && (bl > (pat % 16));
            @(negedge clk);
            irq_pin_i  = 6'(pat);
            cpu_mask_i = 4'(pat % 16);
            wait_cyc(3);
            chk("R9 valid", irq_valid_o, (bl != 0));
            chk("R9 id",    irq_id_o, bi);
            chk("R8 level", irq_level_o, bl);
            chk("R10 cpu_req", cpu_req_o, ecpu);
         end
      end
      irq_pin_i = '0; cpu_mask_i = '0;
      load_prio(0);
      wait_cyc(4);

      // R3: pulse width threshold in edge mode
      reg_write(3'd0, 16'h003F);
      pulse(2, 2);
      wait_cyc(8);
      chk("R3 two-cycle pulse ignored", irq_valid_o, 0);
      reg_read(3'd1, rd); chk("R3 two-cycle pulse pending", rd, 0);
      pulse(2, 3);
      wait_cyc(8);
      // R4: held after pin low
      chk("R4 latched valid", irq_valid_o, 1);
      chk("R4 latched id", irq_id_o, 2);

      // R5: unarmed zero write and one write have no effect
      reg_write(3'd1, 16'h0000);
      chk("R5 unarmed clear ignored", irq_valid_o, 1);
      reg_read(3'd1, rd); chk("R5 read shows bit", rd, 16'h0004);
      reg_write(3'd1, 16'hFFFF);
      chk("R5 write one ignored", irq_valid_o, 1);
      reg_write(3'd1, 16'h0000);
      chk("R5 armed clear", irq_valid_o, 0);
      reg_read(3'd1, rd); chk("R5 pending cleared", rd, 0);

      // R6: edge coincides with clearing write
      pulse(3, 3);
      wait_cyc(6);
      reg_read(3'd1, rd); chk("R6 bit3 set", rd, 16'h0008);
      wait_cyc(4);
      @(negedge clk);
      irq_pin_i[3] = 1'b1;
      repeat (4) @(posedge clk);
      reg_write(3'd1, 16'h0000);
      chk("R6 set wins over clear", irq_valid_o, 1);
      chk("R6 id", irq_id_o, 3);
      reg_write(3'd1, 16'h0000);
      chk("R6 disarmed by new edge", irq_valid_o, 1);
      reg_read(3'd1, rd); chk("R6 rearm read", rd, 16'h0008);
      reg_write(3'd1, 16'h0000);
      chk("R6 cleared after rearm", irq_valid_o, 0);
      @(negedge clk); irq_pin_i[3] = 1'b0;
      wait_cyc(4);

      // R5: stale request revealed by a mode change is cleared by handshake
      pulse(1, 4);
      wait_cyc(6);
      reg_write(3'd0, 16'h0000);
      wait_cyc(1);
      chk("R5 level view hides latch", irq_valid_o, 0);
      reg_write(3'd0, 16'h003F);
      chk("R5 stale request visible", irq_id_o, 1);
      chk("R5 stale valid", irq_valid_o, 1);
      reg_read(3'd1, rd); chk("R5 stale read", rd, 16'h0002);
      reg_write(3'd1, 16'h0000);
      chk("R5 stale cleared", irq_valid_o, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule